// File: doc/BRIEF.md
# Bfloat16 Vector Greater-Than Compare with Predicate Merge

This unit takes two packed vectors of bfloat16 lanes and compares them lane by lane with a floating-point greater-than test. Each bfloat16 value is widened to a single-precision word by putting it in the upper 16 bits and filling the lower 16 bits with zeros. The widened words are then compared under IEEE ordering. The unit produces a predicate with one bit per byte, so each 16-bit lane owns two predicate bits.

A two-bit mode chooses how each lane's new two-bit result is combined with the prior predicate bits of that lane:
- overwrite,
- AND into the prior bits,
- OR into the prior bits,
- XOR into the prior bits.

Inputs are registered once. When `in_valid` is high, the merged predicate appears on `pred_out` with `out_valid` one clock later.

The block has no state machine. It is a single register stage with two states, idle and result-valid, and `out_valid` tracks which one holds. The IDLE→VALID transition happens when `in_valid` is high at a clock edge. The VALID→IDLE transition happens when `in_valid` is low at a clock edge. In IDLE the predicate register keeps its last value.

Top module: `bf16_vcmp_pred`

## Requirements
- R1: With mode 0 (overwrite), lane i (bits 16i+15..16i of each vector) sets predicate bits 2i and 2i+1 to 11 when a > b, and to 00 otherwise. The prior predicate is ignored.
- R2: With mode 1 (AND), each of the lane's two predicate bits becomes prior bit AND the new lane result bit.
- R3: With mode 2 (OR), each of the lane's two predicate bits becomes prior bit OR the new lane result bit.
- R4: With mode 3 (XOR), each of the lane's two predicate bits becomes prior bit XOR the new lane result bit. The two bits are merged independently, so a prior 01 can become 10.
- R5: A lane whose a or b is NaN (exponent all ones, fraction nonzero) yields a false result.
- R6: +0 (0x0000) and −0 (0x8000) compare equal, so greater-than between any two zeros is false.
- R7: Sign is honoured. Between two negative values, the one of smaller magnitude is greater, and any positive nonzero value is greater than any negative value.
- R8: Infinities and subnormals are ordered as values. +inf (0x7F80) is greater than the largest finite value, −inf (0xFF80) is less than every finite value, and a positive subnormal is greater than zero.
- R9: A result appears on `pred_out`, with `out_valid` high, exactly one clock after `in_valid` is sampled high. `out_valid` is low one clock after `in_valid` is sampled low.
- R10: After reset, `pred_out` is all zeros and `out_valid` is 0.
- R11: While `in_valid` is low, `pred_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands, prior predicate and mode are presented this cycle |
| vec_a | input | 8*BYTES | Left operand vector, lane i in bits 16i+15..16i |
| vec_b | input | 8*BYTES | Right operand vector, same lane layout |
| pred_in | input | BYTES | Prior predicate, one bit per byte |
| mode | input | 2 | 0 overwrite, 1 AND, 2 OR, 3 XOR |
| out_valid | output | 1 | `pred_out` holds a result of the previous cycle's request |
| pred_out | output | BYTES | Merged predicate |

## Verification
Every result is due one rising edge after the cycle in which `in_valid` was high. The bench drives inputs on the falling edge and samples outputs on the falling edge that follows the capturing rising edge. The driver task pushes each expected predicate, computed from real-number values of the lanes, onto a queue. The monitor pops one entry on each falling edge where `out_valid` is high, so results are matched to requests strictly in order. After the last request, a fixed idle window is used to check that the held value and the low `out_valid` persist.

// File: rtl/bf16_vcmp_pkg.sv
package bf16_vcmp_pkg;
    typedef enum logic [1:0] {
        MODE_SET = 2'd0,
        MODE_AND = 2'd1,
        MODE_OR  = 2'd2,
        MODE_XOR = 2'd3
    } merge_mode_e;

    localparam int LANE_BITS = 16;
    localparam int LANE_BYTES = 2;
endpackage

// File: rtl/bf16_gt_lane.sv
module bf16_gt_lane
    import bf16_vcmp_pkg::*;
(
    input  logic [LANE_BITS-1:0] a,
    input  logic [LANE_BITS-1:0] b,
    output logic                 gt
);
    logic [31:0] wa, wb;
    logic        a_nan, b_nan, both_zero, mag_gt, mag_lt;

    always_comb begin
        wa        = {a, 16'h0000};
        wb        = {b, 16'h0000};
        a_nan     = (&wa[30:23]) && (|wa[22:0]);
        b_nan     = (&wb[30:23]) && (|wb[22:0]);
        both_zero = ~|wa[30:0] && ~|wb[30:0];
        mag_gt    = wa[30:0] > wb[30:0];
        mag_lt    = wa[30:0] < wb[30:0];
        if (a_nan || b_nan || both_zero)
            gt = 1'b0;
        else if (wa[31] != wb[31])
            gt = ~wa[31];
        else if (wa[31])
            gt = mag_lt;
        else
            gt = mag_gt;
    end
endmodule

// File: rtl/bf16_pred_merge.sv
module bf16_pred_merge
    import bf16_vcmp_pkg::*;
(
    input  merge_mode_e           mode,
    input  logic [LANE_BYTES-1:0] prior,
    input  logic                  gt,
    output logic [LANE_BYTES-1:0] merged
);
    logic [LANE_BYTES-1:0] fresh;

    always_comb begin
        fresh = {LANE_BYTES{gt}};
        unique case (mode)
            MODE_SET: merged = fresh;
            MODE_AND: merged = prior & fresh;
            MODE_OR:  merged = prior | fresh;
            MODE_XOR: merged = prior ^ fresh;
            default:  merged = fresh;
        endcase
    end
endmodule

// File: rtl/bf16_vcmp_pred.sv
module bf16_vcmp_pred
    import bf16_vcmp_pkg::*;
#(
    parameter int BYTES = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [8*BYTES-1:0] vec_a,
    input  logic [8*BYTES-1:0] vec_b,
    input  logic [BYTES-1:0]   pred_in,
    input  logic [1:0]         mode,
    output logic               out_valid,
    output logic [BYTES-1:0]   pred_out
);
    localparam int LANES = BYTES / LANE_BYTES;

    typedef enum logic { ST_IDLE = 1'b0, ST_VALID = 1'b1 } stage_e;

    stage_e           state_q;
    logic [BYTES-1:0] pred_q;
    logic [BYTES-1:0] pred_next;
    merge_mode_e      mode_e;

    assign mode_e = merge_mode_e'(mode);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic gt;
        bf16_gt_lane u_cmp (
            .a (vec_a[LANE_BITS*i +: LANE_BITS]),
            .b (vec_b[LANE_BITS*i +: LANE_BITS]),
            .gt(gt)
        );
        bf16_pred_merge u_mrg (
            .mode  (mode_e),
            .prior (pred_in[LANE_BYTES*i +: LANE_BYTES]),
            .gt    (gt),
            .merged(pred_next[LANE_BYTES*i +: LANE_BYTES])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pred_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_q <= in_valid ? ST_VALID : ST_IDLE;
                ST_VALID: state_q <= in_valid ? ST_VALID : ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
            if (in_valid)
                pred_q <= pred_next;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_VALID);
        pred_out  = pred_q;
    end
endmodule

// File: rtl/bf16_vcmp_pred_chk.sv
module bf16_vcmp_pred_chk
    import bf16_vcmp_pkg::*;
#(
    parameter int BYTES = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [8*BYTES-1:0] vec_a,
    input logic [8*BYTES-1:0] vec_b,
    input logic [BYTES-1:0]   pred_in,
    input logic [1:0]         mode,
    input logic               out_valid,
    input logic [BYTES-1:0]   pred_out
);
    localparam int LANES = BYTES / LANE_BYTES;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> pred_out == $past(pred_out));

    p_and_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(mode) == MODE_AND)
        |-> (pred_out & ~$past(pred_in)) == '0);

    p_or_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(mode) == MODE_OR)
        |-> (pred_out & $past(pred_in)) == $past(pred_in));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        p_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(in_valid) && $past(mode) == MODE_SET)
            |-> pred_out[2*i] == pred_out[2*i+1]);

        p_nan_false_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(in_valid) && $past(mode) == MODE_SET &&
             (&$past(vec_a[16*i+7 +: 8])) && (|$past(vec_a[16*i +: 7])))
            |-> pred_out[2*i +: 2] == 2'b00);
    end
endmodule

bind bf16_vcmp_pred bf16_vcmp_pred_chk #(.BYTES(BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .vec_a    (vec_a),
    .vec_b    (vec_b),
    .pred_in  (pred_in),
    .mode     (mode),
    .out_valid(out_valid),
    .pred_out (pred_out)
);

// File: tb/sim_bf16_vcmp_pred.sv
`timescale 1ns/1ps
module sim_bf16_vcmp_pred;
    localparam int BYTES = 128;
    localparam int LANES = BYTES / 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [8*BYTES-1:0] vec_a = '0;
    logic [8*BYTES-1:0] vec_b = '0;
    logic [BYTES-1:0]   pred_in = '0;
    logic [1:0]         mode = 2'd0;
    logic               out_valid;
    logic [BYTES-1:0]   pred_out;

    always #5 clk = ~clk;

    bf16_vcmp_pred #(.BYTES(BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_a(vec_a), .vec_b(vec_b), .pred_in(pred_in), .mode(mode),
        .out_valid(out_valid), .pred_out(pred_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [BYTES-1:0] exp_q[$];
    string            tag_q[$];
    logic [BYTES-1:0] last_exp = '0;

    logic [15:0] specials [12] = '{16'h0000, 16'h8000, 16'h7F80, 16'hFF80,
                                   16'h7FC0, 16'hFFC1, 16'h0001, 16'h8001,
                                   16'h007F, 16'h3F80, 16'hBF80, 16'h7F7F};

    function automatic bit is_nan(logic [15:0] v);
        return (v[14:7] == 8'hFF) && (v[6:0] != 7'd0);
    endfunction

    function automatic real to_real(logic [15:0] v);
        real mag;
        int  e;
        e = int'(v[14:7]);
        if (e == 255)
            mag = 1.0e300;
        else if (e == 0)
            mag = (real'(v[6:0]) / 128.0) * (2.0 ** (-126.0));
        else
            mag = (1.0 + real'(v[6:0]) / 128.0) * (2.0 ** real'(e - 127));
        return v[15] ? -mag : mag;
    endfunction

    function automatic logic [BYTES-1:0] model(logic [8*BYTES-1:0] a,
                                               logic [8*BYTES-1:0] b,
                                               logic [BYTES-1:0] p,
                                               logic [1:0] m);
        logic [BYTES-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            logic [15:0] la, lb;
            bit          g;
            la = a[16*i +: 16];
            lb = b[16*i +: 16];
            g  = !is_nan(la) && !is_nan(lb) && (to_real(la) > to_real(lb));
            for (int k = 0; k < 2; k++) begin
                case (m)
                    2'd0: r[2*i+k] = g;
                    2'd1: r[2*i+k] = p[2*i+k] & g;
                    2'd2: r[2*i+k] = p[2*i+k] | g;
                    default: r[2*i+k] = p[2*i+k] ^ g;
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [BYTES-1:0] act, logic [BYTES-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [8*BYTES-1:0] a, logic [8*BYTES-1:0] b,
                         logic [BYTES-1:0] p, logic [1:0] m, string tag);
        @(negedge clk);
        vec_a = a; vec_b = b; pred_in = p; mode = m; in_valid = 1'b1;
        last_exp = model(a, b, p, m);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    function automatic logic [8*BYTES-1:0] fill(logic [15:0] v);
        logic [8*BYTES-1:0] r;
        for (int i = 0; i < LANES; i++) r[16*i +: 16] = v;
        return r;
    endfunction

    function automatic logic [8*BYTES-1:0] rand_vec(int special_pct);
        logic [8*BYTES-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            if (($urandom % 100) < special_pct)
                r[16*i +: 16] = specials[$urandom % 12];
            else
                r[16*i +: 16] = 16'($urandom);
        end
        return r;
    endfunction

    function automatic logic [BYTES-1:0] rand_pred();
        logic [BYTES-1:0] r;
        for (int i = 0; i < BYTES; i++) r[i] = 1'($urandom);
        return r;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected out_valid", pred_out, '0);
            end else begin
                logic [BYTES-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pred_out === e, t, pred_out, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [8*BYTES-1:0] a, b;
        repeat (3) @(negedge clk);
        check(pred_out === '0 && out_valid === 1'b0, "R10 reset state",
              pred_out, '0);
        rst_n = 1'b1;

        // R1 overwrite: a>b everywhere, prior all ones/zeros mixed
        drive(fill(16'h4000), fill(16'h3F80), rand_pred(), 2'd0, "R1 set true");
        drive(fill(16'h3F80), fill(16'h4000), {BYTES{1'b1}}, 2'd0, "R1 set false");
        // R5 NaN on either side
        drive(fill(16'h7FC0), fill(16'h0000), '0, 2'd0, "R5 nan a");
        drive(fill(16'h3F80), fill(16'hFFC1), '0, 2'd0, "R5 nan b");
        // R6 signed zeros both ways
        drive(fill(16'h0000), fill(16'h8000), '0, 2'd0, "R6 +0>-0");
        drive(fill(16'h8000), fill(16'h0000), '0, 2'd0, "R6 -0>+0");
        // R7 negatives: -1 > -2 true, -2 > -1 false, +tiny > -big
        drive(fill(16'hBF80), fill(16'hC000), '0, 2'd0, "R7 -1>-2");
        drive(fill(16'hC000), fill(16'hBF80), '0, 2'd0, "R7 -2>-1");
        drive(fill(16'h0001), fill(16'hFF7F), '0, 2'd0, "R7 pos>neg");
        // R8 infinities and subnormals
        drive(fill(16'h7F80), fill(16'h7F7F), '0, 2'd0, "R8 +inf>max");
        drive(fill(16'hFF7F), fill(16'hFF80), '0, 2'd0, "R8 -max>-inf");
        drive(fill(16'h0001), fill(16'h0000), '0, 2'd0, "R8 subnorm>0");
        drive(fill(16'h8001), fill(16'h0000), '0, 2'd0, "R8 -subnorm>0");
        // R2..R4 with mixed prior bits per lane (e.g. 01/10)
        drive(fill(16'h4000), fill(16'h3F80), {(BYTES/2){2'b01}}, 2'd1, "R2 and true");
        drive(fill(16'h3F80), fill(16'h4000), {BYTES{1'b1}}, 2'd1, "R2 and false");
        drive(fill(16'h3F80), fill(16'h4000), {(BYTES/2){2'b10}}, 2'd2, "R3 or false");
        drive(fill(16'h4000), fill(16'h3F80), '0, 2'd2, "R3 or true");
        drive(fill(16'h4000), fill(16'h3F80), {(BYTES/2){2'b01}}, 2'd3, "R4 xor flip");
        drive(fill(16'h3F80), fill(16'h4000), {(BYTES/2){2'b01}}, 2'd3, "R4 xor keep");

        // random mixes, all modes, back-to-back
        for (int n = 0; n < 160; n++) begin
            int m;
            m = n % 4;
            a = rand_vec(40);
            b = (n % 5 == 0) ? a : rand_vec(40);
            drive(a, b, rand_pred(), 2'(m),
                  m == 0 ? "R1 random" : m == 1 ? "R2 random" :
                  m == 2 ? "R3 random" : "R4 random");
        end

        // R11 hold: inputs change while idle
        @(negedge clk);
        in_valid = 1'b0;
        vec_a = fill(16'h7F80); vec_b = fill(16'hFF80); pred_in = '1; mode = 2'd2;
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0, "R9 valid drops", {BYTES{out_valid}}, '0);
        repeat (3) @(negedge clk);
        check(pred_out === last_exp, "R11 hold while idle", pred_out, last_exp);
        check(exp_q.size() == 0, "R9 all results returned", BYTES'(exp_q.size()), '0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule